// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Register Slave

This block is the serial front end of a sensor. It listens on an open-drain two-wire bus. It takes the synchronised clock and data line samples and answers through a single pull-down enable on the data line. An address byte whose upper four bits match a fixed device-type code, and whose next three bits match the strap pins, selects this slave. Up to eight sensors can therefore share one bus. After a write address, the first byte loads an internal pointer. Two further bytes form a 16-bit word, which goes out to the sensor core on a one-cycle write strobe. A read address returns the 16-bit word at the current pointer, high byte first. A read needs no pointer byte: it reuses the pointer from the last write transfer, and a repeated START lets the host set the pointer and then read within one transfer.

The register contents belong to the sensor core, which supplies read data combinationally for the pointer and marks read-only locations. The block holds one register bit of its own: bit 7 of register 0x22. Setting this bit switches off a bus watchdog. While a transfer is open, the watchdog measures how long SCL stays low. When the low time passes a threshold, nominally 30 ms, the watchdog drops the protocol back to idle and releases SDA.

Top module: `smb_sensor_slave`

## Requirements
- R1: An address byte of the form {DEV_TYPE[3:0], strap_i[2:0], rw} is acknowledged, meaning the slave pulls SDA low during the ninth clock. rw=1 selects a read. Any other address byte is not acknowledged, and the slave then ignores the bus until the next START.
- R2: The slave samples data bits on the SCL rising edge, most significant bit first. It changes its own SDA pull-down only while SCL is low.
- R3: The first byte after a matching write address is stored as the pointer, acknowledged, and presented on reg_addr_o.
- R4: The two bytes that follow the pointer are each acknowledged. The second one produces a single-cycle reg_wr_o pulse with reg_wr_data_o = {first byte, second byte} at address reg_addr_o.
- R5: A read returns the word at the pointer, high byte first and then low byte. The low byte is sent only if the host acknowledged the high byte. After a host not-acknowledge, SDA stays released.
- R6: A read without a pointer byte uses the pointer from the last write transfer. A repeated START after the pointer byte switches the transfer to a read.
- R7: A word write whose pointer the core flags through reg_ro_i is acknowledged in full but raises no reg_wr_o.
- R8: If SCL stays low for TIMEOUT_CYC system clocks while a transfer is open, the slave returns to idle and releases SDA. An SCL high phase restarts the count.
- R9: The watchdog is enabled after reset. Writing a word with bit 7 set to register 0x22 disables it, and writing bit 7 clear enables it again. A read of 0x22 returns bit 7 as the disable state and takes the other bits from the core.
- R10: After reset, SDA is released, reg_wr_o is low and the pointer is 0.
- R11: A STOP returns the slave to idle, and a partial word produces no write. A START at any point begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line sample |
| sda_i | input | 1 | SDA line sample |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| strap_i | input | 3 | Low slave address bits |
| reg_addr_o | output | 8 | Pointer toward the sensor core |
| reg_rd_data_i | input | 16 | Core read data at reg_addr_o |
| reg_ro_i | input | 1 | Core flags reg_addr_o read-only |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wr_data_o | output | 16 | Write word |

## Verification
A bit counter or state that slips by one position shows up within a single byte. The acknowledge would land in the wrong clock, or a returned byte would come back rotated, and the bus-level check of that byte reports it. A pointer that is wrong or lost surfaces on the next pointer-less read, which returns data from another location. A stuck watchdog shows within one threshold window of a held SCL: either SDA stays pulled past the limit, or, with the disable bit set, SDA is released when it should not be. Ignored writes are checked by the absence of a strobe and by reading the location back.

// File: rtl/smb_pkg.sv
// Shared types and constants for the two-wire register slave.
// Assumes byte-wide bus transfers and 16-bit registers.
package smb_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_AACK, S_PTR, S_PACK, S_WHI, S_HACK,
        S_WLO, S_LACK, S_RHI, S_RACK1, S_RLO, S_RACK2, S_SKIP
    } smb_state_t;
endpackage

// File: rtl/smb_line_sync.sv
// Synchronises SCL and SDA into the system clock and derives the SCL
// edge events and the START/STOP conditions. Assumes the lines idle high
// and change slowly compared with the system clock.
module smb_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int NLINE = 2;
    logic [NLINE-1:0] raw, st1, st2, prv;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        // two-flop synchroniser plus one delayed copy for edge detection
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st1[g] <= 1'b1;
                st2[g] <= 1'b1;
                prv[g] <= 1'b1;
            end else begin
                st1[g] <= raw[g];
                st2[g] <= st1[g];
                prv[g] <= st2[g];
            end
        end
    end

    assign scl_s    = st2[0];
    assign sda_s    = st2[1];
    assign scl_rise = st2[0] & ~prv[0];
    assign scl_fall = ~st2[0] & prv[0];
    assign start_ev = st2[0] & prv[0] & prv[1] & ~st2[1];
    assign stop_ev  = st2[0] & prv[0] & ~prv[1] & st2[1];
endmodule

// File: rtl/smb_bus_watchdog.sv
// Counts system clocks of continuous SCL-low time while armed and flags
// a timeout when LIMIT is reached. Assumes the flag is consumed by the
// protocol engine, which then disarms the counter by going idle.
module smb_bus_watchdog #(
    parameter int LIMIT = 1_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic scl_s,
    output logic tmo_hit
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] lowcnt;

    assign tmo_hit = armed & ~scl_s & (lowcnt == CW'(LIMIT - 1));

    // low-time counter, cleared whenever SCL is high or the watchdog is idle
    always_ff @(posedge clk) begin
        if (!rst_n || !armed || scl_s || tmo_hit) lowcnt <= '0;
        else                                      lowcnt <= lowcnt + 1'b1;
    end
endmodule

// File: rtl/smb_proto_fsm.sv
// Byte-level protocol engine: address match, pointer load, word write,
// word read, acknowledge handling and the timeout-disable bit. Assumes
// event inputs come from smb_line_sync and read data is combinational.
module smb_proto_fsm
    import smb_pkg::*;
#(
    parameter logic [3:0] DEV_TYPE = 4'b0011,
    parameter int         PTR_W    = 8,
    parameter int         TMO_PTR  = 8'h22,
    parameter int         TMO_BIT  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              tmo_hit,
    input  logic [2:0]        strap_i,
    input  logic [WORD_W-1:0] rd_word,
    input  logic              ro_i,
    output logic              sda_pull,
    output logic [PTR_W-1:0]  ptr,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_data,
    output logic              tmo_dis,
    output logic              busy
);
    smb_state_t        state;
    logic [BYTE_W-1:0] sh, tx, hi;
    logic [WORD_W-1:0] rdw;
    logic [3:0]        cnt;
    logic              rw, hack;
    logic              rx_state, tx_state, byte_done;

    assign busy      = (state != S_IDLE);
    assign rx_state  = (state == S_ADDR) || (state == S_PTR) ||
                       (state == S_WHI)  || (state == S_WLO);
    assign tx_state  = (state == S_RHI)  || (state == S_RLO);
    assign byte_done = scl_fall && (cnt == 4'd8);

    // protocol state, shift registers and SDA drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE; sh <= '0; tx <= '0; hi <= '0; rdw <= '0;
            cnt <= '0; rw <= 1'b0; hack <= 1'b0; sda_pull <= 1'b0;
            ptr <= '0; wr_en <= 1'b0; wr_data <= '0; tmo_dis <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (tmo_hit || stop_ev) begin
                state <= S_IDLE; sda_pull <= 1'b0; cnt <= '0;
            end else if (start_ev) begin
                state <= S_ADDR; sda_pull <= 1'b0; cnt <= '0;
            end else if (rx_state && scl_rise) begin
                sh  <= {sh[BYTE_W-2:0], sda_s};
                cnt <= cnt + 1'b1;
            end else if (rx_state && byte_done) begin
                cnt <= '0;
                sda_pull <= 1'b1;
                case (state)
                    S_ADDR: begin
                        if (sh[7:4] == DEV_TYPE && sh[3:1] == strap_i) begin
                            rw <= sh[0]; state <= S_AACK;
                        end else begin
                            sda_pull <= 1'b0; state <= S_SKIP;
                        end
                    end
                    S_PTR: begin ptr <= PTR_W'(sh); state <= S_PACK; end
                    S_WHI: begin hi <= sh; state <= S_HACK; end
                    default: begin
                        wr_data <= {hi, sh};
                        wr_en   <= ~ro_i;
                        if (ptr == PTR_W'(TMO_PTR) && !ro_i) tmo_dis <= sh[TMO_BIT];
                        state <= S_LACK;
                    end
                endcase
            end else if (tx_state && scl_rise) begin
                cnt <= cnt + 1'b1;
            end else if (tx_state && scl_fall) begin
                if (cnt == 4'd8) begin
                    cnt <= '0; sda_pull <= 1'b0;
                    state <= (state == S_RHI) ? S_RACK1 : S_RACK2;
                end else begin
                    tx <= {tx[BYTE_W-2:0], 1'b0};
                    sda_pull <= ~tx[BYTE_W-2];
                end
            end else if (state == S_RACK1 && scl_rise) begin
                hack <= ~sda_s;
            end else if (scl_fall) begin
                case (state)
                    S_AACK: begin
                        if (rw) begin
                            rdw <= rd_word; tx <= rd_word[WORD_W-1:BYTE_W];
                            sda_pull <= ~rd_word[WORD_W-1]; state <= S_RHI;
                        end else begin
                            sda_pull <= 1'b0; state <= S_PTR;
                        end
                    end
                    S_PACK: begin sda_pull <= 1'b0; state <= S_WHI; end
                    S_HACK: begin sda_pull <= 1'b0; state <= S_WLO; end
                    S_LACK: begin sda_pull <= 1'b0; state <= S_SKIP; end
                    S_RACK1: begin
                        if (hack) begin
                            tx <= rdw[BYTE_W-1:0]; sda_pull <= ~rdw[BYTE_W-1];
                            state <= S_RLO;
                        end else begin
                            state <= S_SKIP;
                        end
                    end
                    S_RACK2: state <= S_SKIP;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/smb_sensor_slave.sv
// Top of the two-wire register slave: line synchroniser, bus watchdog and
// protocol engine, plus the read-data overlay of the locally held
// timeout-disable bit. Assumes the core decodes reg_addr_o combinationally.
module smb_sensor_slave #(
    parameter logic [3:0] DEV_TYPE    = 4'b0011,
    parameter int         TIMEOUT_CYC = 1_500_000,
    parameter int         PTR_W       = 8,
    parameter int         TMO_PTR     = 8'h22,
    parameter int         TMO_BIT     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_pull_o,
    input  logic [2:0]       strap_i,
    output logic [PTR_W-1:0] reg_addr_o,
    input  logic [15:0]      reg_rd_data_i,
    input  logic             reg_ro_i,
    output logic             reg_wr_o,
    output logic [15:0]      reg_wr_data_o
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic tmo_hit, tmo_dis, busy;
    logic [15:0] rd_word;

    smb_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
    );

    smb_bus_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
        .clk(clk), .rst_n(rst_n), .armed(busy & ~tmo_dis),
        .scl_s(scl_s), .tmo_hit(tmo_hit)
    );

    // overlay the local disable bit on reads of the timeout register
    always_comb begin
        rd_word = reg_rd_data_i;
        if (reg_addr_o == PTR_W'(TMO_PTR)) rd_word[TMO_BIT] = tmo_dis;
    end

    smb_proto_fsm #(
        .DEV_TYPE(DEV_TYPE), .PTR_W(PTR_W), .TMO_PTR(TMO_PTR), .TMO_BIT(TMO_BIT)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
        .tmo_hit(tmo_hit), .strap_i(strap_i), .rd_word(rd_word),
        .ro_i(reg_ro_i), .sda_pull(sda_pull_o), .ptr(reg_addr_o),
        .wr_en(reg_wr_o), .wr_data(reg_wr_data_o), .tmo_dis(tmo_dis),
        .busy(busy)
    );
endmodule

// File: rtl/smb_sensor_slave_chk.sv
// Property checker for smb_sensor_slave, attached through bind.
module smb_sensor_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic sda_pull_o,
    input logic reg_wr_o,
    input logic reg_ro_i,
    input logic tmo_hit,
    input logic tmo_dis
);
    a_r2_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_s);
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |=> !reg_wr_o);
    a_r7_no_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |-> !reg_ro_i);
    a_r8_timeout_release: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_hit |=> !sda_pull_o);
    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_dis |-> !tmo_hit);
endmodule

bind smb_sensor_slave smb_sensor_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_pull_o(sda_pull_o),
    .reg_wr_o(reg_wr_o), .reg_ro_i(reg_ro_i), .tmo_hit(tmo_hit),
    .tmo_dis(tmo_dis)
);

// File: tb/smb_sensor_slave_test.sv
module smb_sensor_slave_test;
    localparam int H   = 10;
    localparam int LIM = 400;
    localparam logic [7:0] AW = 8'h3A, AR = 8'h3B, ABAD = 8'h38;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl = 1'b1, h_low = 1'b0;
    logic sda_pull, reg_wr, reg_ro;
    logic [7:0] reg_addr;
    logic [15:0] rd_data, wr_data;
    logic [15:0] mem [256];
    logic [23:0] exp_wr [$];
    wire sda_bus = !(h_low || sda_pull);
    int total = 0, bad = 0;

    always #10 clk = ~clk;

    smb_sensor_slave #(.TIMEOUT_CYC(LIM)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_pull_o(sda_pull), .strap_i(3'b101), .reg_addr_o(reg_addr),
        .reg_rd_data_i(rd_data), .reg_ro_i(reg_ro), .reg_wr_o(reg_wr),
        .reg_wr_data_o(wr_data)
    );

    // sensor-core model: combinational read, two read-only addresses
    assign rd_data = mem[reg_addr];
    assign reg_ro  = (reg_addr == 8'h05) || (reg_addr == 8'h07);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // monitor: pop an expected write on every strobe
    always @(negedge clk) begin
        if (rst_n && reg_wr) begin
            if (exp_wr.size() == 0) begin
                chk(1'b0, "R4/R7 unexpected write", {8'h0, reg_addr, wr_data}, 32'h0);
            end else begin
                logic [23:0] e;
                e = exp_wr.pop_front();
                chk({reg_addr, wr_data} == e, "R4 write addr/data",
                    {8'h0, reg_addr, wr_data}, {8'h0, e});
            end
            mem[reg_addr] = wr_data;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        h_low = 1'b0; tick(H); scl = 1'b1; tick(H);
        h_low = 1'b1; tick(H); scl = 1'b0; tick(H);
    endtask

    task automatic bus_stop();
        h_low = 1'b1; tick(H); scl = 1'b1; tick(H); h_low = 1'b0; tick(H);
    endtask

    task automatic send_bits(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            h_low = !b[i]; tick(H); scl = 1'b1; tick(H); scl = 1'b0; tick(2);
        end
        h_low = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b);
        tick(H); scl = 1'b1; tick(H/2); ack = !sda_bus; tick(H/2);
        scl = 1'b0; tick(2);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        h_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(H); scl = 1'b1; tick(H/2); b[i] = sda_bus; tick(H/2);
            scl = 1'b0; tick(2);
        end
        h_low = give_ack; tick(H); scl = 1'b1; tick(H); scl = 1'b0; tick(2);
        h_low = 1'b0;
    endtask

    task automatic write_word(input logic [7:0] p, input logic [15:0] d, input bit expect_wr);
        bit a;
        bus_start();
        send_byte(AW, a);        chk(a, "R1 write address ack", a, 1);
        send_byte(p, a);         chk(a, "R3 pointer ack", a, 1);
        chk(reg_addr == p, "R3 pointer on reg_addr_o", reg_addr, p);
        send_byte(d[15:8], a);   chk(a, "R4 high byte ack", a, 1);
        if (expect_wr) exp_wr.push_back({p, d});
        send_byte(d[7:0], a);    chk(a, "R4 low byte ack", a, 1);
        bus_stop(); tick(4);
        chk(exp_wr.size() == 0, "R4 write strobe seen", exp_wr.size(), 0);
    endtask

    task automatic read_word(input bit set_ptr, input logic [7:0] p,
                             input logic [15:0] exp, input string tag);
        bit a;
        logic [7:0] hb, lb;
        bus_start();
        if (set_ptr) begin
            send_byte(AW, a); send_byte(p, a);
            bus_start();
        end
        send_byte(AR, a);        chk(a, "R1 read address ack", a, 1);
        recv_byte(1'b1, hb);     chk(hb == exp[15:8], {tag, " high byte"}, hb, exp[15:8]);
        recv_byte(1'b0, lb);     chk(lb == exp[7:0], {tag, " low byte"}, lb, exp[7:0]);
        bus_stop();
    endtask

    initial begin
        bit a;
        logic [7:0] b;
        for (int i = 0; i < 256; i++) mem[i] = {8'(i) ^ 8'h5A, 8'(i)};
        tick(5); rst_n = 1'b1; tick(3);
        // R10: reset state
        chk(!sda_pull, "R10 sda released", sda_pull, 0);
        chk(!reg_wr, "R10 no write", reg_wr, 0);
        chk(reg_addr == 0, "R10 pointer zero", reg_addr, 0);

        // R3 R4: word write
        write_word(8'h04, 16'hBEEF, 1'b1);
        // R5 R6: pointer write, repeated START, read
        read_word(1'b1, 8'h04, 16'hBEEF, "R6 repeated start read");
        // R6: pointer-only transfer, then pointer-less read
        bus_start(); send_byte(AW, a); send_byte(8'h10, a); bus_stop();
        read_word(1'b0, 8'h00, mem[8'h10], "R6 reused pointer read");
        // R2: high-bit-heavy pattern
        write_word(8'h11, 16'h8001, 1'b1);
        read_word(1'b1, 8'h11, 16'h8001, "R2 bit order read");

        // R5: host NACK on first byte, slave must stay off the bus
        bus_start(); send_byte(AR, a);
        recv_byte(1'b0, b);  chk(b == 8'h80, "R5 first byte", b, 8'h80);
        recv_byte(1'b0, b);  chk(b == 8'hFF, "R5 released after nack", b, 8'hFF);
        bus_stop();

        // R1: wrong address not acknowledged, following bytes ignored
        bus_start();
        send_byte(ABAD, a);  chk(!a, "R1 foreign address nack", a, 0);
        send_byte(8'h04, a); chk(!a, "R1 ignored until start", a, 0);
        bus_stop();

        // R7: read-only write acknowledged, no strobe, contents unchanged
        write_word(8'h05, 16'h1234, 1'b0);
        read_word(1'b1, 8'h05, {8'h05 ^ 8'h5A, 8'h05}, "R7 read-only unchanged");

        // R11: STOP after a partial word gives no write
        bus_start(); send_byte(AW, a); send_byte(8'h06, a); send_byte(8'h77, a);
        bus_stop(); tick(4);
        read_word(1'b0, 8'h00, {8'h06 ^ 8'h5A, 8'h06}, "R11 partial word dropped");

        // R8 R9: timeout enabled after reset; slave holds ack, SCL kept low
        bus_start(); send_bits(AW); tick(5);
        chk(!sda_bus, "R1 ack driven", sda_bus, 0);
        tick(300); chk(!sda_bus, "R8 no early release", sda_bus, 0);
        tick(150); chk(sda_bus, "R9 R8 released after timeout", sda_bus, 1);
        scl = 1'b1; tick(H);
        read_word(1'b0, 8'h00, {8'h06 ^ 8'h5A, 8'h06}, "R8 usable after timeout");

        // R9: disable, read back, hold SCL low past the limit
        write_word(8'h22, 16'h0080, 1'b1);
        read_word(1'b1, 8'h22, 16'h0080, "R9 disable bit read");
        bus_start(); send_bits(AW); tick(460);
        chk(!sda_bus, "R9 disabled watchdog holds", sda_bus, 0);
        tick(H); scl = 1'b1; tick(H); scl = 1'b0; tick(2);
        bus_stop();
        write_word(8'h22, 16'h5A00, 1'b1);
        read_word(1'b1, 8'h22, 16'h5A00, "R9 re-enabled bit read");
        bus_start(); send_bits(AW); tick(460);
        chk(sda_bus, "R9 watchdog active again", sda_bus, 1);
        scl = 1'b1; tick(H); bus_stop();

        tick(10);
        chk(exp_wr.size() == 0, "R4 all writes seen", exp_wr.size(), 0);
        finish_run();
    end
endmodule